// File: doc/BRIEF.md
# Tagged Queued DMA Write Controller

This block is the device side of a tagged, queued write command on a parallel disk-style register interface. The host fills a small set of shadow registers: a feature byte whose upper bits hold a command tag, a sector count, three address bytes and a device/head byte. It then writes the queued-write opcode to the command register. The controller holds the interface busy for one cycle while it takes the command. It then looks at whether its data path can accept data.

If the data path is ready, the controller goes straight into the DMA data phase. If it is not, it gives up the bus. In that case the sector count readback reports the tag and the release reason bits, and the service bit in status stays low. The host later resumes the command with a SERVICE command. Once words start to move, the command runs to the end of its sector count without any further release. The controller then returns to ready.

Physical bus timing, CRC and the storage media lie outside this block. It only sequences the command, reports status and drives the DMA request handshake.

Top module: `qdw_top`

## Requirements
- R1: After reset, status reads 40h (ready only), error reads 00h, sector count readback reads 00h and the DMA request is low.
- R2: Device/head readback always shows bits 7 and 5 as 1, with bits 6, 4 and 3-0 as written. The 28-bit start address is {device/head[3:0], cylinder high, cylinder low, sector number}, captured when the queued write (CCh) is accepted.
- R3: In the cycle after CCh is written to the command register (offset 7), status reads 80h (busy) for exactly one cycle. If the data-ready input is high in that cycle, status becomes 58h (ready, service bit 4, data request bit 3) and the DMA request rises.
- R4: If data-ready is low in that cycle, the bus is released. Sector count readback becomes {tag, 1, 0, 0}, where the tag is feature bits 7-3. Status reads 40h with the service bit cleared, and the DMA request stays low.
- R5: SERVICE (A2h) written while a command is released starts its data phase one cycle later, with status 58h and the DMA request high.
- R6: A data phase accepts exactly N x 256 words, one per cycle in which the request and the acknowledge are both high. N is the sector count, and a count of 00h means 256 sectors.
- R7: After the last word, the DMA request and data request drop on the next cycle, status returns to 40h and the service bit is clear.
- R8: A command register write during the data phase is ignored: no release happens and the word total is unchanged.
- R9: Any of the following sets error bit 2 (abort) and status bit 0 (error): an opcode other than CCh or A2h, SERVICE with no command released, or CCh while a command is already released. A released command stays pending. The next accepted command clears both bits.
- R10: An acknowledge given while the DMA request is low moves no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register offset (1 feature, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 device/head, 7 command) |
| host_wdata | input | 8 | Register write data |
| xfer_ready | input | 1 | Data path can take data now |
| dma_ack | input | 1 | Host DMA acknowledge, one word per cycle |
| dma_req | output | 1 | DMA request |
| status_rd | output | 8 | Status readback |
| error_rd | output | 8 | Error readback |
| seccnt_rd | output | 8 | Sector count readback or release report |
| devhead_rd | output | 8 | Device/head readback |
| start_lba | output | 28 | Captured start address |

## Verification
The hardest situation to reach is a command register write that lands in the middle of a long data phase, combined with gaps in the acknowledge. A wrong design would restart or release there, and the only visible sign would be a word total that is off. The stimulus therefore runs random acknowledge gaps, and on some passes injects a CCh write at a chosen word index. The bench then compares the counted words with N x 256. A directed 256-sector pass covers the 00h count, and acknowledge pulses while the command is released probe R10.

// File: rtl/qdw_pkg.sv
package qdw_pkg;
    localparam logic [2:0] A_FEAT = 3'd1;
    localparam logic [2:0] A_SCNT = 3'd2;
    localparam logic [2:0] A_SNUM = 3'd3;
    localparam logic [2:0] A_CYLL = 3'd4;
    localparam logic [2:0] A_CYLH = 3'd5;
    localparam logic [2:0] A_DEVH = 3'd6;
    localparam logic [2:0] A_CMD  = 3'd7;

    localparam logic [7:0] OP_QWRITE  = 8'hCC;
    localparam logic [7:0] OP_SERVICE = 8'hA2;

    localparam int ST_BSY = 7;
    localparam int ST_RDY = 6;
    localparam int ST_SRV = 4;
    localparam int ST_DRQ = 3;
    localparam int ST_ERR = 0;
    localparam int ER_ABT = 2;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ACCEPT,
        SQ_RELEASED,
        SQ_XFER
    } seq_state_e;
endpackage

// File: rtl/qdw_shadow_regs.sv
module qdw_shadow_regs
    import qdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] feat,
    output logic [7:0] scnt,
    output logic [7:0] snum,
    output logic [7:0] cyll,
    output logic [7:0] cylh,
    output logic [7:0] devh
);
    typedef struct packed {
        logic [7:0] feat;
        logic [7:0] scnt;
        logic [7:0] snum;
        logic [7:0] cyll;
        logic [7:0] cylh;
        logic [7:0] devh;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (we) begin
            case (addr)
                A_FEAT:  sh_d.feat = wdata;
                A_SCNT:  sh_d.scnt = wdata;
                A_SNUM:  sh_d.snum = wdata;
                A_CYLL:  sh_d.cyll = wdata;
                A_CYLH:  sh_d.cylh = wdata;
                A_DEVH:  sh_d.devh = wdata;
                default: sh_d = sh_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign feat = sh_q.feat;
    assign scnt = sh_q.scnt;
    assign snum = sh_q.snum;
    assign cyll = sh_q.cyll;
    assign cylh = sh_q.cylh;
    assign devh = sh_q.devh;
endmodule

// File: rtl/qdw_xfer_count.sv
module qdw_xfer_count #(
    parameter int WPS   = 256,
    parameter int SEC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] load_secs,
    input  logic             step,
    output logic             last
);
    localparam int WW = (WPS > 1) ? $clog2(WPS) : 1;
    localparam logic [WW-1:0]    WLAST = WW'(WPS - 1);
    localparam logic [SEC_W-1:0] ONE   = SEC_W'(1);

    typedef struct packed {
        logic [WW-1:0]    word;
        logic [SEC_W-1:0] secs;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d  = c_q;
        last = (c_q.word == WLAST) && (c_q.secs == ONE);
        if (load) begin
            c_d.word = '0;
            c_d.secs = load_secs;
        end else if (step && (c_q.secs != '0)) begin
            if (c_q.word == WLAST) begin
                c_d.word = '0;
                c_d.secs = c_q.secs - ONE;
            end else begin
                c_d.word = c_q.word + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(c_q.word)); // R10
    AST_NO_SECTOR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && c_q.secs == '0) |=> (c_q.secs == '0)); // R6
endmodule

// File: rtl/qdw_seq.sv
module qdw_seq
    import qdw_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter int SEC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_code,
    input  logic [7:0]       feat,
    input  logic [7:0]       scnt,
    input  logic [27:0]      lba_in,
    input  logic             xfer_ready,
    input  logic             dma_ack,
    input  logic             last,
    output seq_state_e       st,
    output logic             abrt,
    output logic [TAG_W-1:0] tag,
    output logic [27:0]      lba,
    output logic             load,
    output logic [SEC_W-1:0] load_secs,
    output logic             step
);
    localparam int TAG_LSB = 8 - TAG_W;

    typedef struct packed {
        seq_state_e       st;
        logic             abrt;
        logic [TAG_W-1:0] tag;
        logic [27:0]      lba;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        load      = 1'b0;
        step      = 1'b0;
        load_secs = (scnt == 8'h00) ? SEC_W'(256) : SEC_W'(scnt);
        case (s_q.st)
            SQ_IDLE: begin
                if (cmd_wr) begin
                    if (cmd_code == OP_QWRITE) begin
                        s_d.st   = SQ_ACCEPT;
                        s_d.abrt = 1'b0;
                        s_d.tag  = feat[7:TAG_LSB];
                        s_d.lba  = lba_in;
                        load     = 1'b1;
                    end else begin
                        s_d.abrt = 1'b1;
                    end
                end
            end
            SQ_ACCEPT: begin
                s_d.st = xfer_ready ? SQ_XFER : SQ_RELEASED;
            end
            SQ_RELEASED: begin
                if (cmd_wr) begin
                    if (cmd_code == OP_SERVICE) begin
                        s_d.st   = SQ_XFER;
                        s_d.abrt = 1'b0;
                    end else begin
                        s_d.abrt = 1'b1;
                    end
                end
            end
            SQ_XFER: begin
                step = dma_ack;
                if (dma_ack && last) s_d.st = SQ_IDLE;
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, abrt: 1'b0, tag: '0, lba: '0};
        else        s_q <= s_d;
    end

    assign st   = s_q.st;
    assign abrt = s_q.abrt;
    assign tag  = s_q.tag;
    assign lba  = s_q.lba;

    AST_ACCEPT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_ACCEPT) |=> (s_q.st != SQ_ACCEPT)); // R3
    AST_SERVICE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_RELEASED && cmd_wr && cmd_code == OP_SERVICE) |=> (s_q.st == SQ_XFER)); // R5
    AST_NO_RELEASE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_XFER) |=> (s_q.st == SQ_XFER || s_q.st == SQ_IDLE)); // R8
    AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_IDLE && cmd_wr && cmd_code != OP_QWRITE) |=> s_q.abrt); // R9
endmodule

// File: rtl/qdw_top.sv
module qdw_top
    import qdw_pkg::*;
#(
    parameter int WPS   = 256,
    parameter int TAG_W = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [7:0]  host_wdata,
    input  logic        xfer_ready,
    input  logic        dma_ack,
    output logic        dma_req,
    output logic [7:0]  status_rd,
    output logic [7:0]  error_rd,
    output logic [7:0]  seccnt_rd,
    output logic [7:0]  devhead_rd,
    output logic [27:0] start_lba
);
    localparam int SEC_W = $clog2(257);

    logic [7:0] feat, scnt, snum, cyll, cylh, devh;
    logic [TAG_W-1:0] tag;
    logic [27:0] lba_cap;
    logic [SEC_W-1:0] load_secs;
    logic load, step, last, abrt, cmd_wr;
    seq_state_e st;

    assign cmd_wr = host_we && (host_addr == A_CMD);

    qdw_shadow_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .feat(feat), .scnt(scnt), .snum(snum), .cyll(cyll), .cylh(cylh), .devh(devh)
    );

    qdw_seq #(.TAG_W(TAG_W), .SEC_W(SEC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(host_wdata),
        .feat(feat), .scnt(scnt), .lba_in({devh[3:0], cylh, cyll, snum}),
        .xfer_ready(xfer_ready), .dma_ack(dma_ack), .last(last),
        .st(st), .abrt(abrt), .tag(tag), .lba(lba_cap),
        .load(load), .load_secs(load_secs), .step(step)
    );

    qdw_xfer_count #(.WPS(WPS), .SEC_W(SEC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_secs(load_secs),
        .step(step), .last(last)
    );

    always_comb begin
        status_rd          = 8'h00;
        status_rd[ST_BSY]  = (st == SQ_ACCEPT);
        status_rd[ST_RDY]  = (st != SQ_ACCEPT);
        status_rd[ST_SRV]  = (st == SQ_XFER);
        status_rd[ST_DRQ]  = (st == SQ_XFER);
        status_rd[ST_ERR]  = abrt;
        error_rd           = 8'h00;
        error_rd[ER_ABT]   = abrt;
        seccnt_rd          = (st == SQ_RELEASED) ? {tag, 3'b100} : scnt;
        devhead_rd         = {1'b1, devh[6], 1'b1, devh[4:0]};
        dma_req            = (st == SQ_XFER);
        start_lba          = lba_cap;
    end

    AST_REQ_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack && last) |=> !dma_req); // R7
endmodule

// File: tb/sim_qdw_top.sv
`timescale 1ns/1ps
module sim_qdw_top;
    localparam int WPS = 256;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, host_we, xfer_ready, dma_ack, dma_req;
    logic [2:0] host_addr;
    logic [7:0] host_wdata, status_rd, error_rd, seccnt_rd, devhead_rd;
    logic [27:0] start_lba;

    int n_run = 0;
    int n_fail = 0;

    qdw_top u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .xfer_ready(xfer_ready), .dma_ack(dma_ack),
        .dma_req(dma_req), .status_rd(status_rd), .error_rd(error_rd),
        .seccnt_rd(seccnt_rd), .devhead_rd(devhead_rd), .start_lba(start_lba)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_words(input logic [7:0] sc);
        return ((sc == 8'h00) ? 256 : int'(sc)) * WPS;
    endfunction

    function automatic logic [7:0] exp_report(input logic [7:0] feat);
        return {feat[7:3], 3'b100};
    endfunction

    function automatic logic [27:0] exp_lba(input logic [7:0] dh, ch, cl, sn);
        return {dh[3:0], ch, cl, sn};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic issue(input logic [7:0] ft, sc, sn, cl, ch, dh, input bit ready);
        wr(3'd1, ft); wr(3'd2, sc); wr(3'd3, sn); wr(3'd4, cl); wr(3'd5, ch); wr(3'd6, dh);
        xfer_ready = ready;
        wr(3'd7, 8'hCC);
        chk("R3 busy after command", status_rd, 8'h80);
        @(negedge clk);
        chk("R2 start address", start_lba, exp_lba(dh, ch, cl, sn));
        chk("R2 devhead readback", devhead_rd, dh | 8'hA0);
        chk("R9 error cleared by accepted command", error_rd, 8'h00);
        if (ready) begin
            chk("R3 direct data phase status", status_rd, 8'h58);
            chk("R3 request raised", dma_req, 1'b1);
        end else begin
            chk("R4 release report", seccnt_rd, exp_report(ft));
            chk("R4 released status", status_rd, 8'h40);
            chk("R4 no request when released", dma_req, 1'b0);
        end
    endtask

    task automatic run_xfer(input bit all_ack, input int inject_at, output int words);
        int guard = 0;
        bit injected = 0;
        words = 0;
        while (dma_req && guard < 80000) begin
            logic ack;
            ack = all_ack ? 1'b1 : (($urandom % 4) != 0);
            if (!injected && words == inject_at) begin
                host_we = 1'b1; host_addr = 3'd7; host_wdata = 8'hCC; injected = 1;
            end else begin
                host_we = 1'b0;
            end
            dma_ack = ack;
            if (ack) words++;
            @(negedge clk);
            guard++;
        end
        dma_ack = 1'b0; host_we = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int words;
        void'($urandom(32'd20240611));
        rst_n = 0; host_we = 0; host_addr = 0; host_wdata = 0; xfer_ready = 0; dma_ack = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset status", status_rd, 8'h40);
        chk("R1 reset error", error_rd, 8'h00);
        chk("R1 reset sector count", seccnt_rd, 8'h00);
        chk("R1 reset request", dma_req, 1'b0);

        wr(3'd7, 8'h20);
        chk("R9 unsupported opcode status", status_rd, 8'h41);
        chk("R9 unsupported opcode error", error_rd, 8'h04);
        wr(3'd7, 8'hA2);
        chk("R9 service with nothing pending", error_rd, 8'h04);

        for (int i = 0; i < 16; i++) begin
            logic [7:0] ft, sc, sn, cl, ch, dh;
            bit rdy;
            ft = 8'($urandom); sc = 8'(1 + $urandom % 3);
            sn = 8'($urandom); cl = 8'($urandom); ch = 8'($urandom);
            dh = 8'($urandom); rdy = ($urandom % 2) == 1;
            issue(ft, sc, sn, cl, ch, dh, rdy);
            if (!rdy) begin
                @(negedge clk); dma_ack = 1'b1;
                repeat (3) @(negedge clk);
                dma_ack = 1'b0;
                chk("R10 ack while released is ignored", status_rd, 8'h40);
                if (i % 4 == 1) begin
                    wr(3'd7, 8'hCC);
                    chk("R9 second queued write while released", error_rd, 8'h04);
                    chk("R9 released command still pending", seccnt_rd, exp_report(ft));
                end
                wr(3'd7, 8'hA2);
                chk("R5 service resumes data phase", status_rd, 8'h58);
                chk("R5 request after service", dma_req, 1'b1);
            end
            run_xfer(1'b0, (i % 3 == 0) ? 5 : -1, words);
            chk((i % 3 == 0) ? "R8 R6 word total with command injected" : "R6 word total",
                words, exp_words(sc));
            chk("R7 status after completion", status_rd, 8'h40);
            chk("R7 request dropped", dma_req, 1'b0);
        end

        issue(8'hF8, 8'h00, 8'h12, 8'h34, 8'h56, 8'hE7, 1'b1);
        run_xfer(1'b1, -1, words);
        chk("R6 zero count means 256 sectors", words, exp_words(8'h00));
        chk("R7 status after long transfer", status_rd, 8'h40);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule